// File: doc/BRIEF.md
# Two-Wire Control Register Write Slave

This block lets a host program an on-chip register file over a two-wire serial control bus. The bus clock and the data line are sampled by the fast system clock. The block finds the start and stop conditions on the bus and matches a 7-bit device address. One pin picks the least significant bit of that address. The block acknowledges each byte by pulling the data line low. The data line is modelled as a data input plus an open-drain pull-low enable.

A write frame is one device-address byte with the write direction, then two data bytes. The upper seven bits of the first data byte name one of 128 registers. The last bit of the first byte and all of the second byte form a 9-bit value. The block commits the value only after the second byte has been acknowledged. It then gives a one-cycle strobe with the address and the data. Any register can be read back through a combinational inspection port.

Top module: `twr_reg_slave`

## Requirements
- R1: A start condition (data falls while the clock is high) received in idle begins a frame. The slave then shifts in eight bits MSB first on rising bus-clock edges: device address bits 6..0, then a direction bit where 0 means write.
- R2: The device address is 7'b0011010 when `addrSel` is low and 7'b0011011 when it is high. A matching address with direction 0 is acknowledged by asserting `sdaPullLow` for the ninth clock pulse.
- R3: On an address mismatch the slave gives no acknowledge. It acknowledges no further byte until a new start condition, and it writes no register.
- R4: A frame whose direction bit is 1 is not acknowledged, and no register is written.
- R5: `sdaPullLow` rises only after the bus clock falls at the end of the eighth bit of a byte. It is low while the eighth bit is high, and it is released after the bus clock falls at the end of the ninth bit.
- R6: The first data byte gives the register address in bits 7..1 and data bit 8 in bit 0. The second byte gives data bits 7..0. Both data bytes are acknowledged.
- R7: After the second data byte has been acknowledged, `wrStrobe` is high for exactly one system clock, with `wrAddr` and `wrData` set to the assembled values. No strobe occurs in any other case.
- R8: A stop condition (data rises while the clock is high) in the middle of a frame aborts it to idle, and no register changes.
- R9: A start condition in the middle of a frame aborts it to idle. No new frame begins until another start arrives from idle, and no register changes.
- R10: After reset `sdaPullLow` and `wrStrobe` are low and every register reads 0.
- R11: `peekData` always shows the register selected by `peekAddr`. A committed write appears there in the same cycle that `wrStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock, asynchronous |
| sdaIn | input | 1 | Wired level of the data line, asynchronous |
| addrSel | input | 1 | Selects the device address LSB |
| peekAddr | input | 7 | Register index for inspection |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| wrStrobe | output | 1 | One-cycle register write strobe |
| wrAddr | output | 7 | Register address of the committed write |
| wrData | output | 9 | Data of the committed write |
| peekData | output | 9 | Contents of register `peekAddr` |

## Verification
The register commit and the inspection read can fall in the same system clock. This happens when `peekAddr` already points at the register that a frame is about to write. The bench keeps `peekAddr` on the target register while the final acknowledge is released. On the cycle where `wrStrobe` is high, it requires `peekData` to equal the new value and not the old one. On every other clock it compares `peekData` with its own model of the register file, so a value that shows up early or late is reported.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 7;
  localparam int HI_W     = BYTE_W - REG_AW;
  localparam int DATA_W   = BYTE_W + HI_W;
  localparam int DEV_AW   = 7;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [DEV_AW-1:0] DEV_BASE = 7'b0011010;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_DATA
  } phase_t;

  typedef struct packed {
    logic shiftEn;
    logic latchReg;
    logic commit;
  } dp_cmd_t;
endpackage

// File: rtl/twr_bus_sync.sv
`timescale 1ns/1ps
module twr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond,
  output logic sdaBit
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclPipe[STAGES-1];
  assign sdaS      = sdaPipe[STAGES-1];
  assign sdaBit    = sdaS;
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/twr_ctrl.sv
`timescale 1ns/1ps
module twr_ctrl
  import twr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startCond,
  input  logic    stopCond,
  input  logic    devMatch,
  output dp_cmd_t cmd,
  output logic    sdaPullLow
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             ackOn;
  logic             busy;
  logic             ackGrant;

  assign busy     = (phase != PH_IDLE);
  assign ackGrant = (phase == PH_DEV) ? devMatch : 1'b1;

  always_comb begin
    cmd          = '0;
    cmd.shiftEn  = busy && sclRise && (bitCnt < LAST_BIT);
    cmd.latchReg = sclFall && ackOn && (phase == PH_REG);
    cmd.commit   = sclFall && ackOn && (phase == PH_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (startCond) begin
      phase  <= busy ? PH_IDLE : PH_DEV;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (stopCond) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (busy) begin
      if (sclRise && (bitCnt < LAST_BIT)) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end else if (sclFall && (bitCnt == LAST_BIT)) begin
        if (!ackOn) begin
          if (ackGrant) ackOn <= 1'b1;
          else          phase <= PH_IDLE;
        end else begin
          ackOn  <= 1'b0;
          bitCnt <= '0;
          case (phase)
            PH_DEV:  phase <= PH_REG;
            PH_REG:  phase <= PH_DATA;
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign sdaPullLow = ackOn;

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopCond |=> (phase == PH_IDLE) && !ackOn);

  // R9
  start_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startCond && busy) |=> (phase == PH_IDLE));

  // R5
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ackOn) |-> $past(sclFall || startCond || stopCond));

  // R5
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOn |-> (bitCnt == LAST_BIT) && busy);
endmodule

// File: rtl/twr_datapath.sv
`timescale 1ns/1ps
module twr_datapath
  import twr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_cmd_t           cmd,
  input  logic              sdaBit,
  input  logic              addrSel,
  input  logic [REG_AW-1:0] peekAddr,
  output logic              devMatch,
  output logic              wrStrobe,
  output logic [REG_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] peekData
);
  localparam int DEPTH = 1 << REG_AW;

  logic [BYTE_W-1:0] shiftReg;
  logic [REG_AW-1:0] regAddrQ;
  logic [HI_W-1:0]   dataHiQ;
  logic [DATA_W-1:0] regFile [DEPTH];
  logic [DATA_W-1:0] newWord;
  logic [DEV_AW-1:0] myAddr;

  assign myAddr   = DEV_BASE | DEV_AW'(addrSel);
  assign devMatch = (shiftReg[BYTE_W-1:1] == myAddr) && !shiftReg[0];
  assign newWord  = {dataHiQ, shiftReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      regAddrQ <= '0;
      dataHiQ  <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= cmd.commit;
      if (cmd.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      if (cmd.latchReg) begin
        regAddrQ <= shiftReg[BYTE_W-1 -: REG_AW];
        dataHiQ  <= shiftReg[HI_W-1:0];
      end
      if (cmd.commit) begin
        wrAddr <= regAddrQ;
        wrData <= newWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (cmd.commit) begin
      regFile[regAddrQ] <= newWord;
    end
  end

  assign peekData = regFile[peekAddr];

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R11
  peek_sees_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && (peekAddr == wrAddr)) |-> (peekData == wrData));
endmodule

// File: rtl/twr_reg_slave.sv
`timescale 1ns/1ps
module twr_reg_slave
  import twr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  logic [REG_AW-1:0] peekAddr,
  output logic              sdaPullLow,
  output logic              wrStrobe,
  output logic [REG_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] peekData
);
  logic    sclRise, sclFall, startCond, stopCond, sdaBit, devMatch;
  dp_cmd_t cmd;

  twr_bus_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaBit(sdaBit)
  );

  twr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .devMatch(devMatch),
    .cmd(cmd), .sdaPullLow(sdaPullLow)
  );

  twr_datapath uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(sdaBit),
    .addrSel(addrSel), .peekAddr(peekAddr), .devMatch(devMatch),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .peekData(peekData)
  );
endmodule

// File: tb/twr_reg_slave_test.sv
`timescale 1ns/1ps
module twr_reg_slave_test;
  localparam int QTR = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclDrv = 1'b1;
  logic       sdaMaster = 1'b1;
  logic       addrSel = 1'b0;
  logic [6:0] peekAddr = '0;
  logic       sdaPullLow, wrStrobe;
  logic [6:0] wrAddr;
  logic [8:0] wrData, peekData;
  logic       sdaLine;

  always #2 clk = ~clk;
  assign sdaLine = sdaMaster & ~sdaPullLow;

  twr_reg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .addrSel(addrSel), .peekAddr(peekAddr), .sdaPullLow(sdaPullLow),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .peekData(peekData)
  );

  typedef struct { int a; int d; } wr_t;
  wr_t expQ[$];
  wr_t cur;
  int  modelMem[128];
  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input int act,
                       input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic setPeek(input int a);
    @(posedge clk);
    peekAddr = 7'(a);
  endtask

  // reference model: expected writes and register contents, every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (wrStrobe) begin
        if (expQ.size() == 0) begin
          check(0, "R7", 1, 0, "unexpected write strobe");
        end else begin
          cur = expQ.pop_front();
          check(int'(wrAddr) == cur.a, "R7", int'(wrAddr), cur.a, "write address");
          check(int'(wrData) == cur.d, "R6", int'(wrData), cur.d, "write data");
          modelMem[cur.a] = cur.d;
        end
      end
      // R11: same-cycle visibility and every-clock contents
      check(int'(peekData) == modelMem[peekAddr], "R11", int'(peekData),
            modelMem[peekAddr], "peek contents");
    end
  end

  task automatic startBit();
    sdaMaster = 1'b1; waitQ();
    sclDrv = 1'b1;    waitQ();
    sdaMaster = 1'b0; waitQ();
    sclDrv = 1'b0;    waitQ();
  endtask

  task automatic stopBit();
    sdaMaster = 1'b0; waitQ();
    sclDrv = 1'b1;    waitQ();
    sdaMaster = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    for (int i = 7; i >= 0; i--) begin
      sdaMaster = b[i]; waitQ();
      sclDrv = 1'b1;    waitQ();
      if (i == 0) check(sdaPullLow == 1'b0, "R5", int'(sdaPullLow), 0, "pull before eighth fall");
      waitQ();
      sclDrv = 1'b0;    waitQ();
    end
    sdaMaster = 1'b1; waitQ();
    sclDrv = 1'b1;    waitQ();
    check(sdaPullLow == expAck, req, int'(sdaPullLow), int'(expAck), "acknowledge");
    waitQ();
    sclDrv = 1'b0;    waitQ();
    check(sdaPullLow == 1'b0, "R5", int'(sdaPullLow), 0, "release after ninth fall");
  endtask

  function automatic logic [7:0] devByte(input bit sel, input bit rd);
    return {6'b001101, sel, rd};
  endfunction

  task automatic goodWrite(input bit sel, input int a, input int d);
    wr_t e;
    addrSel = sel;
    startBit();
    sendByte(devByte(sel, 1'b0), 1'b1, "R2");
    sendByte({7'(a), d[8]}, 1'b1, "R6");
    e.a = a; e.d = d;
    expQ.push_back(e);
    sendByte(d[7:0], 1'b1, "R6");
    stopBit();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      report();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(sdaPullLow == 1'b0, "R10", int'(sdaPullLow), 0, "pull after reset");
    check(wrStrobe == 1'b0, "R10", int'(wrStrobe), 0, "strobe after reset");
    setPeek(127); @(negedge clk);
    check(peekData == 9'd0, "R10", int'(peekData), 0, "register 127 after reset");

    // R1 R2 R6 R7 R11: select low, data MSB set, peek on target
    setPeek(5);
    goodWrite(1'b0, 5, 'h1A5);
    check(peekData == 9'h1A5, "R7", int'(peekData), 'h1A5, "register 5 written");

    // R2: select high, top register
    setPeek(127);
    goodWrite(1'b1, 127, 'h0FF);
    check(peekData == 9'h0FF, "R7", int'(peekData), 'h0FF, "register 127 written");

    // R3: select high but address for select low
    addrSel = 1'b1;
    startBit();
    sendByte(devByte(1'b0, 1'b0), 1'b0, "R3");
    sendByte(8'h0A, 1'b0, "R3");
    stopBit();

    // R4: read direction
    addrSel = 1'b0;
    startBit();
    sendByte(devByte(1'b0, 1'b1), 1'b0, "R4");
    stopBit();

    // R8: stop after first data byte
    setPeek(9);
    startBit();
    sendByte(devByte(1'b0, 1'b0), 1'b1, "R1");
    sendByte({7'd9, 1'b1}, 1'b1, "R6");
    stopBit();
    check(peekData == 9'd0, "R8", int'(peekData), 0, "register 9 after stop abort");

    // R9: start after first data byte, then a byte without new start
    startBit();
    sendByte(devByte(1'b0, 1'b0), 1'b1, "R1");
    sendByte({7'd9, 1'b0}, 1'b1, "R6");
    startBit();
    sendByte(devByte(1'b0, 1'b0), 1'b0, "R9");
    sendByte({7'd9, 1'b0}, 1'b0, "R9");
    stopBit();
    check(peekData == 9'd0, "R9", int'(peekData), 0, "register 9 after start abort");

    // recovery after aborts, overwrite with zero MSB
    goodWrite(1'b0, 9, 'h03C);
    setPeek(5);
    goodWrite(1'b0, 5, 'h100);
    setPeek(0);
    goodWrite(1'b1, 0, 'h1FF);

    repeat (4) waitQ();
    check(expQ.size() == 0, "R7", expQ.size(), 0, "pending writes");
    finished = 1;
    report();
    $finish;
  end
endmodule